// File: doc/BRIEF.md
# Crosswalk-Aware Intersection Light Sequencer

The block drives the three lamps of one intersection signal. Left alone it steps through red, green and yellow, holding each for a fixed number of half-second timebase strobes, and repeats. Red is made of two parts: a waiting part that a pedestrian request can cut short, followed by a fixed lead-in before green, so green always appears a set time after a request is accepted.

An officer input toggles the block in and out of a blinking-yellow service mode; leaving that mode always restarts the sequence at the start of red with a fresh timer. A stop command parks the block in a terminal state with every lamp dark until the next reset. All request inputs are single-cycle pulses in the clock domain, and time advances only on the `tick` strobe, so a system can run it from any timebase.

Top module: `xing_light_ctrl`

## Requirements
- R1: During and after a synchronous reset the block is in the red waiting phase (phase code 0) with only `lamp_red` high and `halted` low.
- R2: With no requests the phases last, in ticks, 12 (red waiting, code 0), 4 (red lead-in, code 1), 10 (green, code 2) and 4 (yellow, code 3), then the sequence returns to code 0 and repeats.
- R3: The phase timer restarts at zero on every phase entry, so the phase changes on the clock edge that takes the N-th tick after entry, N being that phase's dwell.
- R4: A `walk_req` pulse in phase 0 moves the block to phase 1 on the next clock edge; green then follows after 4 more ticks.
- R5: A `walk_req` pulse in phases 1, 2, 3 or 4 changes neither phase, lamps nor timing, and is not remembered for a later red.
- R6: A `police_req` pulse in phases 0 to 3 moves the block to the blinking phase (code 4) on the next edge, with `lamp_yellow` high and the other lamps low.
- R7: In phase 4 red and green stay low and `lamp_yellow` inverts on every tick.
- R8: A `police_req` pulse in phase 4 returns the block to phase 0 with its timer cleared, so the full 12-tick wait follows.
- R9: A `quit_req` pulse in any phase moves the block to the terminal phase (code 5): all lamps low, `halted` high, and every later input except reset is ignored.
- R10: Priority within one cycle is quit, then police, then walk and timed steps.
- R11: In phases 0 to 3 exactly one lamp is high: red in 0 and 1, green in 2, yellow in 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle half-second timebase strobe |
| walk_req | input | 1 | One-cycle pedestrian request |
| police_req | input | 1 | One-cycle service-mode toggle |
| quit_req | input | 1 | One-cycle stop command |
| lamp_red | output | 1 | Red lamp drive |
| lamp_green | output | 1 | Green lamp drive |
| lamp_yellow | output | 1 | Yellow lamp drive |
| halted | output | 1 | High in the terminal phase |
| phase_o | output | 3 | Current phase code (0 to 5) |

## Verification
The assertions watch every cycle for the lamp encoding of each phase, that the terminal phase is dark and never left, that a stop or officer pulse lands in the right phase one edge later, that a pedestrian pulse leaves green untouched, and that the phase timer never reaches its limit. Only the directed scenarios can show the dwell lengths themselves, the 4-tick lead-in after an early request, that a request in yellow is not carried into the next red, the blink rhythm, and the full 12-tick wait after leaving service mode.

// File: rtl/xing_pkg.sv
package xing_pkg;

    typedef enum logic [2:0] {
        PH_WAIT    = 3'd0,
        PH_SOON    = 3'd1,
        PH_GO      = 3'd2,
        PH_CAUTION = 3'd3,
        PH_BLINK   = 3'd4,
        PH_DEAD    = 3'd5
    } phase_e;

    typedef struct packed {
        logic red;
        logic green;
        logic yellow;
    } lamps_t;

    function automatic logic is_cycle_phase(phase_e p);
        return (p == PH_WAIT) || (p == PH_SOON) || (p == PH_GO) || (p == PH_CAUTION);
    endfunction

    function automatic lamps_t steady_lamps(phase_e p);
        lamps_t l;
        l = '0;
        case (p)
            PH_WAIT, PH_SOON: l.red    = 1'b1;
            PH_GO:            l.green  = 1'b1;
            PH_CAUTION:       l.yellow = 1'b1;
            default:          l = '0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/xing_timer.sv
module xing_timer
    import xing_pkg::*;
#(
    parameter int WAIT_T  = 12,
    parameter int SOON_T  = 4,
    parameter int GO_T    = 10,
    parameter int CAUT_T  = 4,
    parameter int BLINK_T = 1,
    parameter int CW      = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  phase_e cur,
    input  logic   restart,
    output logic   expire
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        case (cur)
            PH_WAIT:    limit = CW'(WAIT_T);
            PH_SOON:    limit = CW'(SOON_T);
            PH_GO:      limit = CW'(GO_T);
            PH_CAUTION: limit = CW'(CAUT_T);
            PH_BLINK:   limit = CW'(BLINK_T);
            default:    limit = CW'(1);
        endcase
    end

    assign expire = tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart || expire)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // R3: the elapsed count never reaches the dwell of the current phase
    assert_timer_below_limit_R3: assert property (@(posedge clk) disable iff (rst)
        cnt < limit);

endmodule

// File: rtl/xing_fsm.sv
module xing_fsm
    import xing_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   walk,
    input  logic   police,
    input  logic   quit,
    input  logic   expire,
    output phase_e cur,
    output phase_e nxt
);

    always_comb begin
        nxt = cur;
        if (cur == PH_DEAD) begin
            nxt = PH_DEAD;
        end else if (quit) begin
            nxt = PH_DEAD;
        end else if (police) begin
            nxt = (cur == PH_BLINK) ? PH_WAIT : PH_BLINK;
        end else begin
            case (cur)
                PH_WAIT:    if (walk || expire) nxt = PH_SOON;
                PH_SOON:    if (expire) nxt = PH_GO;
                PH_GO:      if (expire) nxt = PH_CAUTION;
                PH_CAUTION: if (expire) nxt = PH_WAIT;
                default:    nxt = cur;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= PH_WAIT;
        else     cur <= nxt;
    end

    assert_quit_to_dead_R10: assert property (@(posedge clk) disable iff (rst)
        quit |=> (cur == PH_DEAD));

    assert_dead_sticks_R9: assert property (@(posedge clk) disable iff (rst)
        (cur == PH_DEAD) |=> (cur == PH_DEAD));

    assert_police_enters_blink_R6: assert property (@(posedge clk) disable iff (rst)
        (police && !quit && is_cycle_phase(cur)) |=> (cur == PH_BLINK));

    assert_police_leaves_blink_R8: assert property (@(posedge clk) disable iff (rst)
        (police && !quit && cur == PH_BLINK) |=> (cur == PH_WAIT));

    assert_walk_ignored_green_R5: assert property (@(posedge clk) disable iff (rst)
        (walk && !police && !quit && !expire && cur == PH_GO) |=> (cur == PH_GO));

endmodule

// File: rtl/xing_lamps.sv
module xing_lamps
    import xing_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e cur,
    input  phase_e nxt,
    input  logic   expire,
    output lamps_t lamps,
    output logic   halted
);

    logic blink_on;

    always_ff @(posedge clk) begin
        if (rst)
            blink_on <= 1'b0;
        else if (nxt == PH_BLINK && cur != PH_BLINK)
            blink_on <= 1'b1;
        else if (cur == PH_BLINK && nxt == PH_BLINK && expire)
            blink_on <= ~blink_on;
    end

    always_comb begin
        if (cur == PH_BLINK) begin
            lamps        = '0;
            lamps.yellow = blink_on;
        end else begin
            lamps = steady_lamps(cur);
        end
    end

    assign halted = (cur == PH_DEAD);

    assert_one_lamp_R11: assert property (@(posedge clk) disable iff (rst)
        is_cycle_phase(cur) |-> ($countones(lamps) == 1));

    assert_dark_when_halted_R9: assert property (@(posedge clk) disable iff (rst)
        halted |-> (lamps == '0));

    assert_blink_only_yellow_R7: assert property (@(posedge clk) disable iff (rst)
        (cur == PH_BLINK) |-> (!lamps.red && !lamps.green));

    assert_blink_starts_lit_R6: assert property (@(posedge clk) disable iff (rst)
        ((cur == PH_BLINK) && ($past(cur) != PH_BLINK)) |-> lamps.yellow);

endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl
    import xing_pkg::*;
#(
    parameter int WAIT_T  = 12,
    parameter int SOON_T  = 4,
    parameter int GO_T    = 10,
    parameter int CAUT_T  = 4,
    parameter int BLINK_T = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       walk_req,
    input  logic       police_req,
    input  logic       quit_req,
    output logic       lamp_red,
    output logic       lamp_green,
    output logic       lamp_yellow,
    output logic       halted,
    output logic [2:0] phase_o
);

    localparam int MAX_A = (WAIT_T > SOON_T) ? WAIT_T : SOON_T;
    localparam int MAX_B = (GO_T > CAUT_T) ? GO_T : CAUT_T;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T = (MAX_C > BLINK_T) ? MAX_C : BLINK_T;
    localparam int CW    = $clog2(MAX_T + 1);

    phase_e cur;
    phase_e nxt;
    logic   expire;
    lamps_t lamps;

    xing_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .walk   (walk_req),
        .police (police_req),
        .quit   (quit_req),
        .expire (expire),
        .cur    (cur),
        .nxt    (nxt)
    );

    xing_timer #(
        .WAIT_T (WAIT_T),
        .SOON_T (SOON_T),
        .GO_T   (GO_T),
        .CAUT_T (CAUT_T),
        .BLINK_T(BLINK_T),
        .CW     (CW)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .cur    (cur),
        .restart(nxt != cur),
        .expire (expire)
    );

    xing_lamps u_lamps (
        .clk   (clk),
        .rst   (rst),
        .cur   (cur),
        .nxt   (nxt),
        .expire(expire),
        .lamps (lamps),
        .halted(halted)
    );

    assign lamp_red    = lamps.red;
    assign lamp_green  = lamps.green;
    assign lamp_yellow = lamps.yellow;
    assign phase_o     = cur;

endmodule

// File: tb/xing_light_ctrl_tb.sv
module xing_light_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       walk_req = 1'b0;
    logic       police_req = 1'b0;
    logic       quit_req = 1'b0;
    logic       lamp_red, lamp_green, lamp_yellow, halted;
    logic [2:0] phase_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xing_light_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .walk_req   (walk_req),
        .police_req (police_req),
        .quit_req   (quit_req),
        .lamp_red   (lamp_red),
        .lamp_green (lamp_green),
        .lamp_yellow(lamp_yellow),
        .halted     (halted),
        .phase_o    (phase_o)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
        summary();
    end

    // compare {phase, red, green, yellow, halted}
    task automatic chk(string req, logic [2:0] ep, logic er, logic eg, logic ey, logic eh);
        logic [6:0] got, exp;
        got = {phase_o, lamp_red, lamp_green, lamp_yellow, halted};
        exp = {ep, er, eg, ey, eh};
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got phase=%0d r=%b g=%b y=%b h=%b, expected phase=%0d r=%b g=%b y=%b h=%b",
                     req, got[6:4], got[3], got[2], got[1], got[0],
                     ep, er, eg, ey, eh);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pulse(logic w, logic p, logic q, logic t);
        @(negedge clk) begin
            walk_req = w; police_req = p; quit_req = q; tick = t;
        end
        @(negedge clk) begin
            walk_req = 0; police_req = 0; quit_req = 0; tick = 0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 in reset", 3'd0, 1, 0, 0, 0);
        do_reset();
        chk("R1 after reset", 3'd0, 1, 0, 0, 0);
    endtask

    task automatic t_default_cycle();
        do_reset();
        ticks(11); chk("R2 R3 wait 11", 3'd0, 1, 0, 0, 0);
        ticks(1);  chk("R2 wait done", 3'd1, 1, 0, 0, 0);
        ticks(3);  chk("R2 soon 3", 3'd1, 1, 0, 0, 0);
        ticks(1);  chk("R2 R11 green", 3'd2, 0, 1, 0, 0);
        ticks(9);  chk("R2 green 9", 3'd2, 0, 1, 0, 0);
        ticks(1);  chk("R2 R11 yellow", 3'd3, 0, 0, 1, 0);
        ticks(3);  chk("R2 yellow 3", 3'd3, 0, 0, 1, 0);
        ticks(1);  chk("R2 back to red", 3'd0, 1, 0, 0, 0);
        ticks(11); chk("R2 R3 second wait 11", 3'd0, 1, 0, 0, 0);
        ticks(1);  chk("R2 second soon", 3'd1, 1, 0, 0, 0);
    endtask

    task automatic t_early_walk();
        do_reset();
        ticks(3);
        pulse(1, 0, 0, 0); chk("R4 walk jumps to lead-in", 3'd1, 1, 0, 0, 0);
        pulse(1, 0, 0, 0); chk("R5 walk in lead-in ignored", 3'd1, 1, 0, 0, 0);
        ticks(3);          chk("R4 lead-in 3", 3'd1, 1, 0, 0, 0);
        ticks(1);          chk("R4 green after 4", 3'd2, 0, 1, 0, 0);
        ticks(4);
        pulse(1, 0, 0, 0); chk("R5 walk in green ignored", 3'd2, 0, 1, 0, 0);
        ticks(5);          chk("R5 green timing kept", 3'd2, 0, 1, 0, 0);
        ticks(1);          chk("R5 yellow on time", 3'd3, 0, 0, 1, 0);
        pulse(1, 0, 0, 0); chk("R5 walk in yellow ignored", 3'd3, 0, 0, 1, 0);
        ticks(4);          chk("R5 red after yellow", 3'd0, 1, 0, 0, 0);
        ticks(11);         chk("R5 walk not remembered", 3'd0, 1, 0, 0, 0);
    endtask

    task automatic t_blink();
        do_reset();
        ticks(12 + 4 + 2);
        pulse(0, 1, 0, 0); chk("R6 police from green", 3'd4, 0, 0, 1, 0);
        ticks(1);          chk("R7 blink off", 3'd4, 0, 0, 0, 0);
        ticks(1);          chk("R7 blink on", 3'd4, 0, 0, 1, 0);
        pulse(1, 0, 0, 0); chk("R5 walk in blink ignored", 3'd4, 0, 0, 1, 0);
        ticks(1);          chk("R7 blink off again", 3'd4, 0, 0, 0, 0);
        pulse(0, 1, 0, 0); chk("R8 resume at red", 3'd0, 1, 0, 0, 0);
        ticks(11);         chk("R8 timer cleared 11", 3'd0, 1, 0, 0, 0);
        ticks(1);          chk("R8 full wait then lead-in", 3'd1, 1, 0, 0, 0);
    endtask

    task automatic t_priority();
        do_reset();
        ticks(11);
        pulse(0, 1, 0, 1); chk("R10 police beats timed step", 3'd4, 0, 0, 1, 0);
        do_reset();
        pulse(1, 1, 0, 0); chk("R10 police beats walk", 3'd4, 0, 0, 1, 0);
        do_reset();
        pulse(0, 1, 1, 0); chk("R10 quit beats police", 3'd5, 0, 0, 0, 1);
    endtask

    task automatic t_quit();
        do_reset();
        ticks(12 + 4 + 10 + 1);
        pulse(0, 0, 1, 0); chk("R9 quit from yellow", 3'd5, 0, 0, 0, 1);
        ticks(20);         chk("R9 ticks ignored", 3'd5, 0, 0, 0, 1);
        pulse(1, 1, 0, 0); chk("R9 requests ignored", 3'd5, 0, 0, 0, 1);
        do_reset();        chk("R1 R9 reset leaves dead", 3'd0, 1, 0, 0, 0);
        pulse(0, 1, 0, 0);
        pulse(0, 0, 1, 0); chk("R9 quit from blink", 3'd5, 0, 0, 0, 1);
    endtask

    initial begin
        t_reset();
        t_default_cycle();
        t_early_walk();
        t_blink();
        t_priority();
        t_quit();
        summary();
    end

endmodule